// File: doc/BRIEF.md
# Single-Channel Block-Move Bus Master

This block moves a block of words between one peripheral and memory without the processor touching each word. While the processor owns the system bus it programs three values through a small register port: the first memory address, the number of words, and the direction of the move. When the peripheral then signals that it wants service, the block asks the processor for the bus. Once the bus is granted, the block signals the peripheral that it is being served and moves one word at a time. After each word it advances the address and lowers the remaining count.

A move from the peripheral into memory takes one cycle per word: the peripheral's data goes straight out as a memory write. A move from memory to the peripheral takes two cycles per word. The block first issues a synchronous memory read, and the returned word is handed to the peripheral in the next cycle. When the count runs out, the block withdraws its bus request. Once the processor has taken the bus back, the block raises a one-cycle completion interrupt. If the peripheral withdraws its request partway through, the block keeps the bus and waits.

Top module: `dma_ctl`

## Requirements
- R1: With a nonzero word count, bus grant low and the controller idle, a high `dev_req` makes `bus_req` high in the next cycle.
- R2: With a word count of zero, `bus_req` stays low whatever `dev_req` does.
- R3: `dev_ack` rises in the cycle after the controller samples `bus_grant` high, and it is only ever high while `bus_grant` is high.
- R4: In peripheral-to-memory mode (direction bit 0), each cycle with `dev_ack` and `dev_req` high writes `dev_din` to memory at the current address (`mem_wr`), one word per cycle, and pulses `dev_xfer`.
- R5: In memory-to-peripheral mode (direction bit 1), each word issues `mem_rd` at the current address. In the following cycle `dev_dout` carries `mem_rdata` and `dev_xfer` pulses.
- R6: After each word the address register rises by one and the word count falls by one. Both are visible through the register port.
- R7: In the cycle after the last word, `bus_req` and `dev_ack` are both low.
- R8: After the last word, `done_irq` is high for exactly one cycle. That cycle is the one after the controller samples `bus_grant` low.
- R9: Register writes are ignored while `bus_req` or `bus_grant` is high.
- R10: While the peripheral's request is low during a transfer, no memory access occurs, `bus_req` stays high, and the address and count hold.
- R11: Register port selects: `cpu_sel`=0 start address, 1 word count, 2 control (bit 0 = direction). Each reads back on `cpu_rdata` combinationally and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Register write strobe from the processor |
| cpu_sel | input | 2 | Register select |
| cpu_wdata | input | DW | Register write data |
| cpu_rdata | output | DW | Register read data |
| dev_req | input | 1 | Service request from the peripheral |
| dev_ack | output | 1 | Peripheral is being served |
| dev_din | input | DW | Word from the peripheral |
| dev_dout | output | DW | Word to the peripheral |
| dev_xfer | output | 1 | One word moved this cycle |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after `mem_rd` |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| done_irq | output | 1 | One-cycle end-of-block interrupt |

## Verification
The request appears one cycle after the peripheral asks. The acknowledge and the first write appear one cycle after the grant is raised. A peripheral-to-memory block of N words holds the bus for exactly N further cycles, and the interrupt comes one cycle after the grant falls. Read data reaches the peripheral one cycle after each memory read. The bench changes inputs on the falling clock edge and samples at the next falling edges, counting the stated number of edges. It never polls for these timed results. Only the total completion of longer transfers is awaited, under a bounded timeout.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a peripheral request
    ST_ASK,    // bus requested, grant not yet seen
    ST_MOVE,   // bus owned, one word per cycle (or read issue)
    ST_FETCH,  // read data returning, hand it to the peripheral
    ST_HAND,   // bus request withdrawn, waiting for grant to fall
    ST_NOTE    // one-cycle completion interrupt
  } dma_state_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          step,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          dir_q,
  output logic          cnt_zero,
  output logic          cnt_last
);
  import dma_pkg::*;

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  function automatic logic [AW-1:0] addr_advance(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_retire(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_ADDR: addr_q <= AW'(wdata);
        SEL_CNT:  cnt_q  <= CW'(wdata);
        SEL_CTRL: dir_q  <= wdata[0];
        default: ;
      endcase
    end else if (step) begin
      addr_q <= addr_advance(addr_q);
      cnt_q  <= cnt_retire(cnt_q);
    end
  end

  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CNT_ONE);

  always_comb begin
    case (sel)
      SEL_ADDR: rdata = DW'(addr_q);
      SEL_CNT:  rdata = DW'(cnt_q);
      SEL_CTRL: rdata = DW'(dir_q);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_req,
  input  logic bus_grant,
  input  logic dir,
  input  logic cnt_zero,
  input  logic cnt_last,
  output logic bus_req,
  output logic dev_ack,
  output logic mem_rd,
  output logic mem_wr,
  output logic step,
  output logic done_irq
);
  import dma_pkg::*;

  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (dev_req && !cnt_zero && !bus_grant) state_d = ST_ASK;
      ST_ASK:   if (bus_grant) state_d = ST_MOVE;
      ST_MOVE:  if (bus_grant && dev_req) begin
                  if (dir)           state_d = ST_FETCH;
                  else if (cnt_last) state_d = ST_HAND;
                end
      ST_FETCH: if (bus_grant) state_d = cnt_last ? ST_HAND : ST_MOVE;
      ST_HAND:  if (!bus_grant) state_d = ST_NOTE;
      ST_NOTE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  logic owning;
  assign owning   = (state_q == ST_MOVE) || (state_q == ST_FETCH);
  assign bus_req  = (state_q == ST_ASK) || owning;
  assign dev_ack  = owning && bus_grant;
  assign mem_wr   = (state_q == ST_MOVE) && bus_grant && dev_req && !dir;
  assign mem_rd   = (state_q == ST_MOVE) && bus_grant && dev_req && dir;
  assign step     = mem_wr || ((state_q == ST_FETCH) && bus_grant);
  assign done_irq = (state_q == ST_NOTE);
endmodule

// File: rtl/dma_ctl.sv
module dma_ctl #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          dev_req,
  output logic          dev_ack,
  input  logic [DW-1:0] dev_din,
  output logic [DW-1:0] dev_dout,
  output logic          dev_xfer,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          done_irq
);
  // named internal events, watched by the bound checker
  logic          reg_wr_ok;
  logic          word_step;
  logic          cnt_zero;
  logic          cnt_last;
  logic          dir_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;

  assign reg_wr_ok = cpu_wr && !bus_grant && !bus_req;

  dma_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_ok),
    .sel      (cpu_sel),
    .wdata    (cpu_wdata),
    .rdata    (cpu_rdata),
    .step     (word_step),
    .addr_q   (addr_q),
    .cnt_q    (cnt_q),
    .dir_q    (dir_q),
    .cnt_zero (cnt_zero),
    .cnt_last (cnt_last)
  );

  dma_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_req   (dev_req),
    .bus_grant (bus_grant),
    .dir       (dir_q),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last),
    .bus_req   (bus_req),
    .dev_ack   (dev_ack),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .step      (word_step),
    .done_irq  (done_irq)
  );

  assign mem_addr  = addr_q;
  assign mem_wdata = dev_din;
  assign dev_dout  = mem_rdata;
  assign dev_xfer  = word_step;
endmodule

// File: rtl/dma_ctl_chk.sv
module dma_ctl_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dev_req,
  input logic          dev_ack,
  input logic          dev_xfer,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          done_irq,
  input logic          cpu_wr,
  input logic          word_step,
  input logic          cnt_zero,
  input logic          cnt_last,
  input logic [AW-1:0] addr_q,
  input logic [CW-1:0] cnt_q
);
  assert_no_req_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !bus_grant) |-> !bus_req);

  assert_ack_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> (bus_grant && bus_req));

  assert_mem_only_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> dev_ack);

  assert_read_then_hand_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && bus_grant) |=> dev_xfer);

  assert_count_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_step && !cpu_wr) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  assert_addr_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_step && !cpu_wr) |=> (addr_q == $past(addr_q) + AW'(1)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_step && cnt_last) |=> (!bus_req && !dev_ack));

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  assert_irq_bus_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!bus_req && !bus_grant));

  assert_pause_no_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> dev_req);

  assert_pause_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !word_step && !cpu_wr && !cnt_zero) |=> ($stable(cnt_q) && $stable(addr_q)));
endmodule

bind dma_ctl dma_ctl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dev_req   (dev_req),
  .dev_ack   (dev_ack),
  .dev_xfer  (dev_xfer),
  .bus_req   (bus_req),
  .bus_grant (bus_grant),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .done_irq  (done_irq),
  .cpu_wr    (cpu_wr),
  .word_step (word_step),
  .cnt_zero  (cnt_zero),
  .cnt_last  (cnt_last),
  .addr_q    (addr_q),
  .cnt_q     (cnt_q)
);

// File: tb/dma_ctl_bench.sv
module dma_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [1:0]    cpu_sel = 2'd0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          dev_req = 1'b0;
  logic          dev_ack;
  logic [DW-1:0] dev_din;
  logic [DW-1:0] dev_dout;
  logic          dev_xfer;
  logic          bus_req;
  logic          bus_grant;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_rd;
  logic          mem_wr;
  logic          done_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ctl #(.DW(DW), .AW(AW), .CW(CW)) u_dma_ctl (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dev_req(dev_req),
    .dev_ack(dev_ack), .dev_din(dev_din), .dev_dout(dev_dout),
    .dev_xfer(dev_xfer), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .done_irq(done_irq)
  );

  // processor grant model: automatic (one cycle late) or driven by a task
  logic auto_gnt = 1'b1;
  logic man_gnt  = 1'b0;
  logic gnt_q    = 1'b0;
  always @(posedge clk) gnt_q <= bus_req;
  assign bus_grant = auto_gnt ? gnt_q : man_gnt;

  // memory, peripheral and event counters
  logic [DW-1:0] ram [0:255];
  logic [DW-1:0] rx  [0:63];
  int pidx = 0, ridx = 0, wr_cnt = 0, rd_cnt = 0, hand_after_rd = 0;
  logic prev_rd = 1'b0;
  assign dev_din = 16'hA000 + DW'(pidx);

  always @(posedge clk) begin
    if (mem_wr) ram[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr[7:0]];
    if (mem_wr) wr_cnt <= wr_cnt + 1;
    if (mem_rd) rd_cnt <= rd_cnt + 1;
    prev_rd <= mem_rd;
    if (dev_xfer) begin
      pidx <= pidx + 1;
      if (prev_rd) begin
        rx[ridx[5:0]] <= dev_dout;
        ridx <= ridx + 1;
        hand_after_rd <= hand_after_rd + 1;
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;
  int p2m_base = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_sel = sel; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [DW-1:0] d);
    cpu_sel = sel;
    #1;
    d = cpu_rdata;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!done_irq && n < 200) begin @(negedge clk); n++; end
    check({tag, " completion seen"}, done_irq, 1'b1);
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    @(negedge clk);
    check("R11 reset bus_req", bus_req, 0);
    check("R11 reset dev_ack", dev_ack, 0);
    check("R11 reset done_irq", done_irq, 0);
    reg_read(2'd0, d); check("R11 reset addr", d, 0);
    reg_read(2'd1, d); check("R11 reset count", d, 0);
    reg_read(2'd2, d); check("R11 reset ctrl", d, 0);
  endtask

  task automatic t_regmap;
    logic [DW-1:0] d;
    reg_write(2'd0, 16'h0123);
    reg_write(2'd1, 16'h0005);
    reg_write(2'd2, 16'h0001);
    reg_read(2'd0, d); check("R11 addr readback", d, 16'h0123);
    reg_read(2'd1, d); check("R11 count readback", d, 16'h0005);
    reg_read(2'd2, d); check("R11 ctrl readback", d, 16'h0001);
  endtask

  task automatic t_zero_count;
    int seen = 0;
    reg_write(2'd1, 16'h0000);
    reg_write(2'd2, 16'h0000);
    @(negedge clk); dev_req = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (bus_req) seen++;
    end
    dev_req = 1'b0;
    check("R2 no request with zero count", seen, 0);
  endtask

  task automatic t_p2m;
    int w0;
    logic [DW-1:0] d;
    auto_gnt = 1'b0; man_gnt = 1'b0;
    reg_write(2'd0, 16'h0040);
    reg_write(2'd1, 16'h0004);
    reg_write(2'd2, 16'h0000);
    p2m_base = pidx;
    @(negedge clk); dev_req = 1'b1;
    @(negedge clk);
    check("R1 bus_req one cycle after dev_req", bus_req, 1);
    check("R3 no ack before grant", dev_ack, 0);
    man_gnt = 1'b1; w0 = wr_cnt;
    @(negedge clk);
    check("R3 ack one cycle after grant", dev_ack, 1);
    check("R4 first write with ack", mem_wr, 1);
    repeat (4) @(negedge clk);
    check("R7 bus_req low after last word", bus_req, 0);
    check("R7 dev_ack low after last word", dev_ack, 0);
    check("R4 one write per cycle", wr_cnt - w0, 4);
    check("R8 no irq while grant held", done_irq, 0);
    man_gnt = 1'b0;
    @(negedge clk);
    check("R8 irq after grant falls", done_irq, 1);
    @(negedge clk);
    check("R8 irq lasts one cycle", done_irq, 0);
    dev_req = 1'b0;
    for (int i = 0; i < 4; i++)
      check("R4 memory word", ram[8'h40 + i], 16'hA000 + DW'(p2m_base + i));
    reg_read(2'd0, d); check("R6 address advanced", d, 16'h0044);
    reg_read(2'd1, d); check("R6 count exhausted", d, 16'h0000);
    auto_gnt = 1'b1;
  endtask

  task automatic t_m2p;
    int r0, h0, rd0;
    reg_write(2'd0, 16'h0040);
    reg_write(2'd1, 16'h0004);
    reg_write(2'd2, 16'h0001);
    r0 = ridx; h0 = hand_after_rd; rd0 = rd_cnt;
    @(negedge clk); dev_req = 1'b1;
    wait_irq("R5");
    dev_req = 1'b0;
    check("R5 reads issued", rd_cnt - rd0, 4);
    check("R5 each read handed next cycle", hand_after_rd - h0, 4);
    for (int i = 0; i < 4; i++)
      check("R5 peripheral word", rx[6'(r0 + i)], 16'hA000 + DW'(p2m_base + i));
  endtask

  task automatic t_pause;
    int w0, p0, n, bad;
    logic [DW-1:0] d;
    reg_write(2'd0, 16'h0080);
    reg_write(2'd1, 16'h0003);
    reg_write(2'd2, 16'h0000);
    @(negedge clk); dev_req = 1'b1;
    n = 0;
    while (!dev_ack && n < 20) begin @(negedge clk); n++; end
    dev_req = 1'b0;
    w0 = wr_cnt; p0 = pidx; bad = 0;
    reg_write(2'd1, 16'h0009);  // must be ignored: bus is held
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!bus_req || mem_wr) bad++;
    end
    check("R10 bus held with no access", bad, 0);
    check("R10 no writes while paused", wr_cnt - w0, 0);
    reg_read(2'd1, d); check("R10 count held while paused", d, 16'h0003);
    dev_req = 1'b1;
    wait_irq("R10");
    dev_req = 1'b0;
    check("R9 write during hold ignored, three words moved", wr_cnt - w0, 3);
    for (int i = 0; i < 3; i++)
      check("R10 memory word after resume", ram[8'h80 + i], 16'hA000 + DW'(p0 + i));
    reg_read(2'd1, d); check("R9 count not overwritten", d, 16'h0000);
    reg_read(2'd0, d); check("R6 address after resume", d, 16'h0083);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_zero_count();
    t_p2m();
    t_m2p();
    t_pause();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule